// File: doc/BRIEF.md
# Port Output Register with Bitwise Set, Clear and Toggle Aliases

This block is the output side of one general-purpose I/O port. It keeps a data output word that drives the port pins directly. Software reaches it over a small single-cycle register bus. That bus has an address, a write strobe, write data, a read strobe and read data.

The data word can be written whole at its own offset. Three further write-only offsets change only the bits that are written as 1. One forces those bits high, one forces them low, and one inverts them. Any subset of pins can therefore be changed in one bus write, without reading the word first. The three alias offsets always read back as zero.

Accesses are word-aligned. Any address that does not select one of the four registers is ignored on write and reads as zero.

Top module: `pout_port`

## Requirements
- R1: While reset is asserted and after its release, the data output word and `pin_out` are all zeros.
- R2: A write to byte offset 0x0 loads `bus_wdata` into the data output word at the rising clock edge of the write cycle.
- R3: A write to byte offset 0x4 (set alias) drives every data bit whose written bit is 1 to 1 and leaves the other bits unchanged.
- R4: A write to byte offset 0x8 (clear alias) drives every data bit whose written bit is 1 to 0 and leaves the other bits unchanged.
- R5: A write to byte offset 0xC (toggle alias) inverts every data bit whose written bit is 1 and leaves the other bits unchanged.
- R6: A read of offset 0x4, 0x8 or 0xC returns 32'h0000_0000.
- R7: A read of offset 0x0 returns the current data output word in the same cycle, before any write in that cycle takes effect.
- R8: A write to an offset other than 0x0/0x4/0x8/0xC changes no state, and a read of such an offset returns zero. This includes an address whose two low bits are not both zero.
- R9: `bus_rdata` is zero in any cycle where `bus_rd` is low.
- R10: `pin_out` equals the data output word at all times and shows a written value from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 6 | Byte offset from the port base |
| bus_wr | input | 1 | Write strobe, one transfer per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid in the cycle of `bus_rd` |
| pin_out | output | 32 | Port pin output vector |

## Verification
Read data is combinational, so it is due in the same cycle as the read strobe. The bench drives every transfer just after a falling edge and samples `bus_rdata` 1 ns later, still before the next rising edge. A write lands at the rising edge that ends its cycle, so `pin_out` is compared with the bench model at the following falling edge. The model is updated only at that point, so a read issued with a write in the same cycle is checked against the old word.

// File: rtl/pout_pkg.sv
package pout_pkg;

    localparam int NUM_REGS = 4;

    // Word index of each register; the decoder and the update logic both rely on it.
    typedef enum int {
        IDX_DATA = 0,
        IDX_SET  = 1,
        IDX_CLR  = 2,
        IDX_TGL  = 3
    } reg_idx_e;

endpackage

// File: rtl/pout_decode.sv
module pout_decode #(
    parameter int ADDR_W = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ADDR_W-1:0]             addr,
    output logic [pout_pkg::NUM_REGS-1:0] hit
);
    import pout_pkg::*;

    localparam int IDX_W = ADDR_W - 2;

    logic             aligned;
    logic [IDX_W-1:0] word_idx;

    assign aligned  = (addr[1:0] == 2'b00);
    assign word_idx = addr[ADDR_W-1:2];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_hit
        assign hit[i] = aligned && (word_idx == IDX_W'(i));
    end

    // R8: at most one register selected, none for misaligned addresses
    p_onehot_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));
    p_misaligned_none_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (addr[1:0] != 2'b00) |-> (hit == '0));

endmodule

// File: rtl/pout_update.sv
module pout_update #(
    parameter int DATA_W = 32
) (
    input  logic                          wr,
    input  logic [pout_pkg::NUM_REGS-1:0] hit,
    input  logic [DATA_W-1:0]             wdata,
    input  logic [DATA_W-1:0]             cur,
    output logic [DATA_W-1:0]             nxt
);
    import pout_pkg::*;

    always_comb begin
        nxt = cur;
        if (wr) begin
            if (hit[IDX_DATA]) begin
                nxt = wdata;
            end else if (hit[IDX_SET]) begin
                nxt = cur | wdata;
            end else if (hit[IDX_CLR]) begin
                nxt = cur & ~wdata;
            end else if (hit[IDX_TGL]) begin
                nxt = cur ^ wdata;
            end
        end
    end

endmodule

// File: rtl/pout_rdmux.sv
module pout_rdmux #(
    parameter int DATA_W = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          rd,
    input  logic [pout_pkg::NUM_REGS-1:0] hit,
    input  logic [DATA_W-1:0]             dout,
    output logic [DATA_W-1:0]             rdata
);
    import pout_pkg::*;

    logic alias_hit;

    assign alias_hit = hit[IDX_SET] | hit[IDX_CLR] | hit[IDX_TGL];

    always_comb begin
        rdata = '0;
        if (rd && hit[IDX_DATA]) begin
            rdata = dout;
        end
    end

    // R6: alias offsets read as zero
    p_alias_reads_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && alias_hit) |-> (rdata == '0));
    // R9: idle read bus is zero
    p_idle_rdata_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |-> (rdata == '0));

endmodule

// File: rtl/pout_port.sv
module pout_port #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] pin_out
);
    import pout_pkg::*;

    typedef struct packed {
        logic [DATA_W-1:0] dout;
    } state_t;

    state_t            st_d, st_q;
    logic [NUM_REGS-1:0] hit;
    logic [DATA_W-1:0] upd_nxt;

    pout_decode #(.ADDR_W(ADDR_W)) u_decode (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (bus_addr),
        .hit   (hit)
    );

    pout_update #(.DATA_W(DATA_W)) u_update (
        .wr    (bus_wr),
        .hit   (hit),
        .wdata (bus_wdata),
        .cur   (st_q.dout),
        .nxt   (upd_nxt)
    );

    pout_rdmux #(.DATA_W(DATA_W)) u_rdmux (
        .clk   (clk),
        .rst_n (rst_n),
        .rd    (bus_rd),
        .hit   (hit),
        .dout  (st_q.dout),
        .rdata (bus_rdata)
    );

    always_comb begin
        st_d      = st_q;
        st_d.dout = upd_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pin_out = st_q.dout;

    // R1: word is zero on the first edge after reset release
    p_reset_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pin_out == '0));
    // R2: full write loads the word
    p_full_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && hit[IDX_DATA]) |=> (pin_out == $past(bus_wdata)));
    // R3: set alias
    p_set_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && hit[IDX_SET]) |=> (pin_out == ($past(pin_out) | $past(bus_wdata))));
    // R4: clear alias
    p_clear_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && hit[IDX_CLR]) |=> (pin_out == ($past(pin_out) & ~$past(bus_wdata))));
    // R5: toggle alias
    p_toggle_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && hit[IDX_TGL]) |=> (pin_out == ($past(pin_out) ^ $past(bus_wdata))));
    // R8: no write, or write to unmapped offset, keeps the word
    p_hold_unmapped_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr || (hit == '0)) |=> $stable(pin_out));
    // R7: data read returns the pin word
    p_data_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && hit[IDX_DATA]) |-> (bus_rdata == pin_out));

endmodule

// File: tb/tb_pout_port.sv
module tb_pout_port;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 6;
    localparam int DATA_W     = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic              bus_rd = 1'b0;
    logic [DATA_W-1:0] bus_rdata;
    logic [DATA_W-1:0] pin_out;

    int n_checks = 0;
    int n_fail   = 0;
    logic [DATA_W-1:0] exp_word = '0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pout_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .pin_out   (pin_out)
    );

    function automatic logic [DATA_W-1:0] f_next(logic [ADDR_W-1:0] a,
                                                 logic [DATA_W-1:0] old,
                                                 logic [DATA_W-1:0] w);
        case (a)
            6'h00:   return w;
            6'h04:   return old | w;
            6'h08:   return old & ~w;
            6'h0C:   return old ^ w;
            default: return old;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] f_read(logic [ADDR_W-1:0] a,
                                                 logic [DATA_W-1:0] cur);
        return (a == 6'h00) ? cur : '0;
    endfunction

    task automatic check(string req, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One bus cycle: drive after a falling edge, check read data 1 ns later,
    // then check the pin word at the next falling edge.
    task automatic bus_cycle(logic [ADDR_W-1:0] a, logic wr, logic rd,
                             logic [DATA_W-1:0] w, string req);
        bus_addr  = a;
        bus_wr    = wr;
        bus_rd    = rd;
        bus_wdata = w;
        #1;
        check({req, " rdata"}, bus_rdata, rd ? f_read(a, exp_word) : '0);
        @(negedge clk);
        if (wr) exp_word = f_next(a, exp_word, w);
        bus_wr = 1'b0;
        bus_rd = 1'b0;
        check({req, " pin_out"}, pin_out, exp_word);
    endtask

    initial begin
        @(negedge clk);
        check("R1 in reset", pin_out, '0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", pin_out, '0);
        bus_cycle(6'h00, 1'b0, 1'b1, '0, "R1 read after reset");

        // Directed corners
        bus_cycle(6'h00, 1'b1, 1'b0, 32'hA5A5_0F0F, "R2 full write");
        bus_cycle(6'h00, 1'b0, 1'b1, '0, "R7 data read");
        bus_cycle(6'h04, 1'b1, 1'b0, 32'h0000_00F0, "R3 set");
        bus_cycle(6'h04, 1'b1, 1'b0, 32'h0000_0000, "R3 set zero mask");
        bus_cycle(6'h08, 1'b1, 1'b0, 32'hA000_000F, "R4 clear");
        bus_cycle(6'h08, 1'b1, 1'b0, 32'h0000_0000, "R4 clear zero mask");
        bus_cycle(6'h0C, 1'b1, 1'b0, 32'hFFFF_FFFF, "R5 toggle all");
        bus_cycle(6'h0C, 1'b1, 1'b0, 32'h8000_0001, "R5 toggle edges");
        bus_cycle(6'h04, 1'b0, 1'b1, '0, "R6 set read");
        bus_cycle(6'h08, 1'b0, 1'b1, '0, "R6 clear read");
        bus_cycle(6'h0C, 1'b0, 1'b1, '0, "R6 toggle read");
        bus_cycle(6'h10, 1'b1, 1'b1, 32'h1234_5678, "R8 unmapped");
        bus_cycle(6'h01, 1'b1, 1'b1, 32'hFFFF_FFFF, "R8 misaligned");
        bus_cycle(6'h3C, 1'b1, 1'b1, 32'hFFFF_FFFF, "R8 top offset");
        bus_cycle(6'h00, 1'b1, 1'b1, 32'h0BAD_F00D, "R7 read with write");
        bus_cycle(6'h00, 1'b0, 1'b0, '0, "R9 idle");
        bus_cycle(6'h00, 1'b0, 1'b1, '0, "R10 pin equals read");

        // Constrained random mix
        void'($urandom(32'd605));
        for (int i = 0; i < 400; i++) begin
            logic [ADDR_W-1:0] a;
            int pick = $urandom_range(0, 9);
            case (pick)
                0, 1:    a = 6'h00;
                2, 3:    a = 6'h04;
                4, 5:    a = 6'h08;
                6, 7:    a = 6'h0C;
                8:       a = ADDR_W'($urandom_range(4, 15) * 4);
                default: a = ADDR_W'($urandom_range(0, 63)) | 6'h01;
            endcase
            bus_cycle(a, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                      $urandom(), "R2-R10 random");
        end
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (5000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule